// File: doc/BRIEF.md
# Modulo Address Generator for Vector Memory Operands

This block turns the addressing field of an issued instruction into an operand address for a banked vector memory. It keeps a small file of pointer registers. Each pointer has its own step and its own lower and upper bound. Every issued access names one addressing mode and one pointer. The address for that access appears on `mem_addr` in the same cycle, with no register stage. The selected pointer then takes its post-modified value at the next clock edge.

Five addressing modes exist. The first uses the instruction's immediate as the address. The other four use the selected pointer as the address and differ in how they update it: the pointer is held, incremented by one, advanced by its step, or advanced by its step with a wrap to the lower bound once it passes the upper bound. The last mode lets a loop walk a circular table, such as round constants or message-schedule indices, with no software instructions spent on bounds. Software loads the pointer values, steps and bounds through a configuration write port.

Top module: `agu_modulo`

## Requirements
- R1: Mode code 0 (immediate) drives `issue_imm` onto `mem_addr` and changes no pointer.
- R2: Mode code 1 (hold) drives the selected pointer onto `mem_addr` and leaves that pointer unchanged at the next edge.
- R3: Mode code 2 (increment) drives the selected pointer onto `mem_addr`, and at the next edge that pointer becomes its old value plus 1, modulo 2^ADDR_W.
- R4: Mode code 3 (stride) drives the selected pointer onto `mem_addr`, and at the next edge that pointer becomes its old value plus its step, modulo 2^ADDR_W.
- R5: Mode code 4 (circular) drives the selected pointer onto `mem_addr`. It forms pointer plus step without truncation. If that sum is strictly greater than the pointer's upper bound, the pointer is loaded with its lower bound. Otherwise the pointer takes the sum, and a sum equal to the upper bound is kept.
- R6: Mode codes 5 to 7 behave exactly like mode code 1.
- R7: When `issue_valid` is low, no pointer changes because of the issue inputs. `mem_addr` still follows the mode, register and immediate inputs.
- R8: A configuration write with `cfg_we` high stores `cfg_data` into field `cfg_field` of pointer `cfg_reg`, visible from the next cycle. The field codes are: 0 pointer value, 1 step, 2 lower bound, 3 upper bound.
- R9: A configuration write to a pointer value takes priority over an issue update of the same pointer in the same cycle. An issue update of a different pointer in that cycle still takes effect.
- R10: After reset, every pointer value, step and bound is zero.
- R11: An issue updates at most one pointer, the one selected by `issue_reg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An access is issued this cycle |
| issue_mode | input | 3 | Addressing mode code |
| issue_reg | input | REG_IDX_W (2) | Pointer selected by the access |
| issue_imm | input | ADDR_W (8) | Immediate address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 2 | Configuration field code |
| cfg_reg | input | REG_IDX_W (2) | Pointer whose field is written |
| cfg_data | input | ADDR_W (8) | Configuration write data |
| mem_addr | output | ADDR_W (8) | Operand address for this cycle |

## Verification
A pointer that holds a wrong value stays invisible until the next access that selects it in a non-immediate mode. On that cycle `mem_addr` shows the error, with no added latency. The bench therefore re-reads a pointer with a hold-mode access right after each corner case: a wrap at the upper bound, an overflow past 2^ADDR_W, a configuration write colliding with an update, and an issue with `issue_valid` low. A wrong step or bound shows up one access later, through the pointer that it produced.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_IMM    = 3'd0,
    AM_HOLD   = 3'd1,
    AM_INC    = 3'd2,
    AM_STRIDE = 3'd3,
    AM_CIRC   = 3'd4
  } am_e;

  typedef enum logic [1:0] {
    CF_PTR  = 2'd0,
    CF_STEP = 2'd1,
    CF_LO   = 2'd2,
    CF_HI   = 2'd3
  } cf_e;

  // Modes that write a new pointer value back.
  function automatic logic mode_updates(logic [2:0] m);
    return (m == AM_INC) || (m == AM_STRIDE) || (m == AM_CIRC);
  endfunction

endpackage

// File: rtl/agu_cfg_bank.sv
module agu_cfg_bank
  import agu_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_field,
  input  logic [IW-1:0]              cfg_reg,
  input  logic [ADDR_W-1:0]          cfg_data,
  output logic [NUM_REGS*ADDR_W-1:0] step_flat,
  output logic [NUM_REGS*ADDR_W-1:0] lo_flat,
  output logic [NUM_REGS*ADDR_W-1:0] hi_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cfg
    logic [ADDR_W-1:0] step_q, lo_q, hi_q;
    logic              hit;

    assign hit = cfg_we && (cfg_reg == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        step_q <= '0;
        lo_q   <= '0;
        hi_q   <= '0;
      end else if (hit) begin
        case (cfg_field)
          CF_STEP: step_q <= cfg_data;
          CF_LO:   lo_q   <= cfg_data;
          CF_HI:   hi_q   <= cfg_data;
          default: ;
        endcase
      end
    end

    assign step_flat[g*ADDR_W +: ADDR_W] = step_q;
    assign lo_flat[g*ADDR_W +: ADDR_W]   = lo_q;
    assign hi_flat[g*ADDR_W +: ADDR_W]   = hi_q;
  end

endmodule

// File: rtl/agu_next_calc.sv
module agu_next_calc
  import agu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] step,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic [ADDR_W-1:0] nxt,
  output logic              upd,
  output logic              wrap
);

  // Sum that drops the carry: increment and stride modes.
  function automatic logic [ADDR_W-1:0] add_mod(logic [ADDR_W-1:0] a,
                                                logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  // Sum that keeps the carry: the circular bound test needs it.
  function automatic logic [ADDR_W:0] add_full(logic [ADDR_W-1:0] a,
                                               logic [ADDR_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [ADDR_W:0] circ_sum;

  always_comb begin
    circ_sum = add_full(ptr, step);
    wrap     = 1'b0;
    nxt      = ptr;
    case (mode)
      AM_INC:    nxt = add_mod(ptr, ADDR_W'(1));
      AM_STRIDE: nxt = add_mod(ptr, step);
      AM_CIRC: begin
        wrap = circ_sum > {1'b0, hi};
        nxt  = wrap ? lo : circ_sum[ADDR_W-1:0];
      end
      default:   nxt = ptr;
    endcase
  end

  assign upd = mode_updates(mode);

endmodule

// File: rtl/agu_ptr_bank.sv
module agu_ptr_bank #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd_valid,
  input  logic [IW-1:0]              upd_reg,
  input  logic [ADDR_W-1:0]          upd_val,
  input  logic                       load_we,
  input  logic [IW-1:0]              load_reg,
  input  logic [ADDR_W-1:0]          load_val,
  output logic [NUM_REGS*ADDR_W-1:0] ptr_flat,
  output logic [NUM_REGS-1:0]        upd_en
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ptr
    logic [ADDR_W-1:0] p_q;
    logic              load_hit;

    assign load_hit  = load_we && (load_reg == IW'(g));
    assign upd_en[g] = upd_valid && (upd_reg == IW'(g));

    // A software load wins over a post-modify in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         p_q <= '0;
      else if (load_hit)  p_q <= load_val;
      else if (upd_en[g]) p_q <= upd_val;
    end

    assign ptr_flat[g*ADDR_W +: ADDR_W] = p_q;
  end

endmodule

// File: rtl/agu_modulo.sv
module agu_modulo
  import agu_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int ADDR_W    = 8,
  parameter int REG_IDX_W = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_valid,
  input  logic [2:0]           issue_mode,
  input  logic [REG_IDX_W-1:0] issue_reg,
  input  logic [ADDR_W-1:0]    issue_imm,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_field,
  input  logic [REG_IDX_W-1:0] cfg_reg,
  input  logic [ADDR_W-1:0]    cfg_data,
  output logic [ADDR_W-1:0]    mem_addr
);

  localparam int FLAT_W = NUM_REGS * ADDR_W;

  logic [FLAT_W-1:0]   ptr_flat, step_flat, lo_flat, hi_flat;
  logic [NUM_REGS-1:0] upd_en;
  logic [ADDR_W-1:0]   sel_ptr, sel_step, sel_lo, sel_hi, next_ptr;
  logic                mode_upd, wrap_hit, upd_fire, ptr_load;

  agu_cfg_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_field (cfg_field),
    .cfg_reg   (cfg_reg),
    .cfg_data  (cfg_data),
    .step_flat (step_flat),
    .lo_flat   (lo_flat),
    .hi_flat   (hi_flat)
  );

  assign sel_ptr  = ptr_flat[issue_reg*ADDR_W +: ADDR_W];
  assign sel_step = step_flat[issue_reg*ADDR_W +: ADDR_W];
  assign sel_lo   = lo_flat[issue_reg*ADDR_W +: ADDR_W];
  assign sel_hi   = hi_flat[issue_reg*ADDR_W +: ADDR_W];

  agu_next_calc #(.ADDR_W(ADDR_W)) u_calc (
    .mode (issue_mode),
    .ptr  (sel_ptr),
    .step (sel_step),
    .lo   (sel_lo),
    .hi   (sel_hi),
    .nxt  (next_ptr),
    .upd  (mode_upd),
    .wrap (wrap_hit)
  );

  assign upd_fire = issue_valid && mode_upd;
  assign ptr_load = cfg_we && (cfg_field == CF_PTR);

  agu_ptr_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_fire),
    .upd_reg   (issue_reg),
    .upd_val   (next_ptr),
    .load_we   (ptr_load),
    .load_reg  (cfg_reg),
    .load_val  (cfg_data),
    .ptr_flat  (ptr_flat),
    .upd_en    (upd_en)
  );

  assign mem_addr = (issue_mode == AM_IMM) ? issue_imm : sel_ptr;

endmodule

// File: rtl/agu_modulo_sva.sv
module agu_modulo_sva
  import agu_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int ADDR_W    = 8,
  parameter int REG_IDX_W = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       issue_valid,
  input logic [2:0]                 issue_mode,
  input logic [REG_IDX_W-1:0]       issue_reg,
  input logic [ADDR_W-1:0]          issue_imm,
  input logic                       cfg_we,
  input logic [1:0]                 cfg_field,
  input logic [REG_IDX_W-1:0]       cfg_reg,
  input logic [ADDR_W-1:0]          cfg_data,
  input logic [ADDR_W-1:0]          mem_addr,
  input logic [NUM_REGS*ADDR_W-1:0] ptr_flat,
  input logic [NUM_REGS*ADDR_W-1:0] lo_flat,
  input logic [NUM_REGS-1:0]        upd_en,
  input logic                       wrap_hit
);

  logic [ADDR_W-1:0] ptr_a [NUM_REGS];
  logic [ADDR_W-1:0] lo_a  [NUM_REGS];
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign ptr_a[g] = ptr_flat[g*ADDR_W +: ADDR_W];
    assign lo_a[g]  = lo_flat[g*ADDR_W +: ADDR_W];
  end

  logic [ADDR_W-1:0] chk_lo;
  logic              load_same;
  assign chk_lo    = lo_a[issue_reg];
  assign load_same = cfg_we && (cfg_field == CF_PTR) && (cfg_reg == issue_reg);

  assert_imm_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_mode == AM_IMM) |-> (mem_addr == issue_imm));

  assert_imm_keeps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_mode == AM_IMM && !cfg_we) |=> $stable(ptr_flat));

  assert_ptr_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_mode != AM_IMM) |-> (mem_addr == ptr_a[issue_reg]));

  assert_inc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_mode == AM_INC && !load_same)
      |=> (ptr_a[$past(issue_reg)] == ($past(mem_addr) + ADDR_W'(1))));

  assert_wrap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && wrap_hit && !load_same)
      |=> (ptr_a[$past(issue_reg)] == $past(chk_lo)));

  assert_idle_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_valid && !cfg_we) |=> $stable(ptr_flat));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_field == CF_PTR)
      |=> (ptr_a[$past(cfg_reg)] == $past(cfg_data)));

  assert_single_update_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_en));

endmodule

bind agu_modulo agu_modulo_sva #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W)
) u_agu_modulo_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_mode  (issue_mode),
  .issue_reg   (issue_reg),
  .issue_imm   (issue_imm),
  .cfg_we      (cfg_we),
  .cfg_field   (cfg_field),
  .cfg_reg     (cfg_reg),
  .cfg_data    (cfg_data),
  .mem_addr    (mem_addr),
  .ptr_flat    (ptr_flat),
  .lo_flat     (lo_flat),
  .upd_en      (upd_en),
  .wrap_hit    (wrap_hit)
);

// File: tb/agu_modulo_bench.sv
`timescale 1ns/1ps
module agu_modulo_bench;

  localparam int N = 4;
  localparam int W = 8;
  localparam int RANDOM_CYCLES = 4000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue_valid = 1'b0;
  logic [2:0]   issue_mode = '0;
  logic [1:0]   issue_reg = '0;
  logic [W-1:0] issue_imm = '0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_field = '0;
  logic [1:0]   cfg_reg = '0;
  logic [W-1:0] cfg_data = '0;
  logic [W-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_ptr [N];
  int m_step[N];
  int m_lo  [N];
  int m_hi  [N];

  always #2 clk = ~clk;

  agu_modulo u_agu_modulo (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_mode(issue_mode),
    .issue_reg(issue_reg), .issue_imm(issue_imm),
    .cfg_we(cfg_we), .cfg_field(cfg_field), .cfg_reg(cfg_reg),
    .cfg_data(cfg_data), .mem_addr(mem_addr)
  );

  function automatic string req_of(int mode);
    case (mode)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Reference post-modify in plain integer arithmetic.
  function automatic int model_next(int mode, int p, int s, int lo, int hi);
    int t;
    case (mode)
      2: return (p + 1) % 256;
      3: return (p + s) % 256;
      4: begin
        t = p + s;
        if (t > hi) return lo;
        return t;
      end
      default: return p;
    endcase
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(bit v, int mode, int r, int imm,
                     bit we, int fld, int cr, int cd, string extra);
    int exp_addr;
    int nxt;
    @(negedge clk);
    issue_valid = v;
    issue_mode  = 3'(mode);
    issue_reg   = 2'(r);
    issue_imm   = W'(imm);
    cfg_we      = we;
    cfg_field   = 2'(fld);
    cfg_reg     = 2'(cr);
    cfg_data    = W'(cd);
    #1;
    exp_addr = (mode == 0) ? imm : m_ptr[r];
    check((extra != "") ? extra : req_of(mode), int'(mem_addr), exp_addr);
    nxt = model_next(mode, m_ptr[r], m_step[r], m_lo[r], m_hi[r]);
    @(posedge clk);
    if (v) m_ptr[r] = nxt;
    if (we) begin
      case (fld)
        0: m_ptr[cr]  = cd;
        1: m_step[cr] = cd;
        2: m_lo[cr]   = cd;
        default: m_hi[cr] = cd;
      endcase
    end
  endtask

  task automatic cfg(int fld, int r, int d);
    cyc(0, 1, r, 0, 1, fld, r, d, "R8");
  endtask

  task automatic peek(int r, string req);
    cyc(0, 1, r, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      m_ptr[i] = 0; m_step[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10: reset state, pointers and steps read back as zero
    for (int i = 0; i < N; i++) peek(i, "R10");
    cyc(1, 3, 0, 0, 0, 0, 0, 0, "R10");
    peek(0, "R10");

    // R8: program fields
    cfg(0, 1, 10); cfg(1, 1, 3); cfg(2, 1, 10); cfg(3, 1, 16);
    peek(1, "R8");

    // R1: immediate leaves pointer alone
    cyc(1, 0, 1, 200, 0, 0, 0, 0, "R1");
    peek(1, "R1");
    // R2: hold
    cyc(1, 1, 1, 0, 0, 0, 0, 0, "R2");
    peek(1, "R2");
    // R5: 10 -> 13 -> 16 (equal to upper bound kept) -> wrap to 10
    cyc(1, 4, 1, 0, 0, 0, 0, 0, "R5");
    cyc(1, 4, 1, 0, 0, 0, 0, 0, "R5");
    peek(1, "R5");
    cyc(1, 4, 1, 0, 0, 0, 0, 0, "R5");
    peek(1, "R5");
    // R5: carry past 2^W must wrap, not keep truncated sum
    cfg(0, 2, 250); cfg(1, 2, 10); cfg(2, 2, 5); cfg(3, 2, 255);
    cyc(1, 4, 2, 0, 0, 0, 0, 0, "R5");
    peek(2, "R5");
    // R3 / R4: modular wrap
    cfg(0, 3, 255);
    cyc(1, 2, 3, 0, 0, 0, 0, 0, "R3");
    peek(3, "R3");
    cfg(1, 3, 200); cfg(0, 3, 100);
    cyc(1, 3, 3, 0, 0, 0, 0, 0, "R4");
    peek(3, "R4");
    // R6: undefined codes hold
    for (int c = 5; c < 8; c++) begin
      cyc(1, c, 3, 0, 0, 0, 0, 0, "R6");
      peek(3, "R6");
    end
    // R7: no update without issue_valid
    cyc(0, 2, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 4, 1, 0, 0, 0, 0, 0, "R7");
    peek(0, "R7"); peek(1, "R7");
    // R9: load wins on same pointer, other pointer still updates
    cyc(1, 2, 0, 0, 1, 0, 0, 77, "R9");
    peek(0, "R9");
    cyc(1, 2, 0, 0, 1, 0, 1, 40, "R9");
    peek(0, "R9"); peek(1, "R9");
    // R11: only selected pointer moves
    cyc(1, 2, 2, 0, 0, 0, 0, 0, "R11");
    for (int i = 0; i < N; i++) peek(i, "R11");

    // Constrained random mix
    for (int k = 0; k < RANDOM_CYCLES; k++) begin
      int md;
      md = ($urandom % 8 < 6) ? int'($urandom % 5) : int'($urandom % 8);
      cyc(($urandom % 4) != 0, md, int'($urandom % N), int'($urandom % 256),
          ($urandom % 6) == 0, int'($urandom % 4), int'($urandom % N),
          int'($urandom % 256), "");
    end
    for (int i = 0; i < N; i++) peek(i, "R2");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule